// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences exception, interrupt and trap entry for a small 32-bit processor core, and the return that follows. Each cycle it looks at seven event request lines: reserved instruction, address fault, floating-point fault, reset event, system break, external interrupt and trap. It also sees three pipeline flags that say whether an instruction is executing, whether the pipeline is between instructions, and whether that gap is word-aligned. Every event class has its own acceptance point. Events that fail their acceptance condition are dropped in that cycle. Of the eligible events, exactly one is taken, chosen by a fixed priority.

On entry the block copies the mode, interrupt-enable and carry status bits into backup bits. It then clears interrupt-enable and carry, and keeps or clears the mode bit depending on the event class. It writes the class's return address into the saved-PC register and issues a one-cycle program-counter load with the class's vector address. On a return strobe it restores the three status bits from their backups and loads the program counter from the saved-PC register. The core updates the status bits through a write port during normal execution.

Top module: `excSequencer`

## Requirements
- R1: While `rstN` is low, and immediately once it falls, all status bits and backup bits are 0, `bpc` is 0, `pcLoad` is 0, `acceptVec` is 0 and `pcTarget` holds the reset-event vector 0x30.
- R2: A reserved-instruction request is taken only while `instExec` is 1, and so is an address-fault request. Either one loads `bpc` with `curPc` and leaves the mode bit unchanged. Such a request without `instExec` has no effect.
- R3: A floating-point request is taken only while `instBoundary` is 1. It loads `bpc` with `curPc`+4 and leaves the mode bit unchanged.
- R4: A reset-event request is taken in any cycle, whatever the pipeline flags. It vectors to 0x30, clears mode, interrupt-enable and carry, and leaves `bpc` unchanged.
- R5: A system-break or external-interrupt request is taken only when `instBoundary` and `wordBoundary` are both 1. It loads `bpc` with `nextPc` and clears the mode bit.
- R6: An external-interrupt request is ignored while the interrupt-enable bit is 0.
- R7: A trap request is taken only while `instBoundary` is 1. It loads `bpc` with `curPc`+4 and leaves the mode bit unchanged.
- R8: Every taken event copies mode, interrupt-enable and carry into `bsmBit`, `bieBit` and `bcBit`, then clears interrupt-enable and carry.
- R9: When several eligible events are requested in one cycle, only one is taken. The priority order is reset event, address fault, reserved instruction, floating-point, trap, system break, external interrupt. A request that is not eligible does not block a lower-priority eligible one.
- R10: `evtReq` and `acceptVec` share one bit mapping: bit0 reserved instruction, bit1 address fault, bit2 floating-point, bit3 reset event, bit4 system break, bit5 external interrupt, bit6 trap. The vector for bit n is 0x10·n. Taking an event shows up one cycle after the request is sampled: `pcLoad` is high for that one cycle, `acceptVec` is one-hot and `pcTarget` holds the vector.
- R11: `rteStrobe` restores mode, interrupt-enable and carry from their backups, and one cycle later drives `pcLoad` with `pcTarget` equal to `bpc`. If an event is taken in the same cycle, the event wins and the return has no effect.
- R12: When no event or return occurs, `pswWe` loads the status bits from `pswWd`, where bit2 is mode, bit1 is interrupt-enable and bit0 is carry. An event or return in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtReq | input | 7 | Event requests, one bit per class |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Address of the next instruction |
| instExec | input | 1 | An instruction is executing |
| instBoundary | input | 1 | Pipeline is between instructions |
| wordBoundary | input | 1 | The boundary is word-aligned |
| rteStrobe | input | 1 | Return-from-exception request |
| pswWe | input | 1 | Status-bit write enable from the core |
| pswWd | input | 3 | Status-bit write data {mode, int-enable, carry} |
| pcLoad | output | 1 | One-cycle program-counter load |
| pcTarget | output | 32 | Address to load into the program counter |
| acceptVec | output | 7 | One-hot class of the event just taken |
| smBit | output | 1 | Mode bit |
| ieBit | output | 1 | Interrupt-enable bit |
| cBit | output | 1 | Carry bit |
| bsmBit | output | 1 | Backup of the mode bit |
| bieBit | output | 1 | Backup of the interrupt-enable bit |
| bcBit | output | 1 | Backup of the carry bit |
| bpc | output | 32 | Saved return address |

## Verification
All results of a taken event or a return are due on the first rising edge after the request is sampled: `pcLoad`, `pcTarget`, `acceptVec`, the status and backup bits, and `bpc`. Status writes land on that same edge. The bench changes inputs on the falling edge and compares every output 1 ns after the next rising edge, so each check reads the registered result of exactly one stimulus cycle. An idle cycle follows a load to show that the load pulse has dropped. Reset is asynchronous, so its state is checked 1 ns after `rstN` falls, with no clock edge in between.

// File: rtl/excSeqPkg.sv
package excSeqPkg;

  localparam int NUM_EVT = 7;
  localparam int EVT_IDX_W = $clog2(NUM_EVT);

  // Bit positions of the request and accept vectors.
  typedef enum logic [EVT_IDX_W-1:0] {
    EV_RIE  = 3'd0,
    EV_AE   = 3'd1,
    EV_FPE  = 3'd2,
    EV_RST  = 3'd3,
    EV_SBI  = 3'd4,
    EV_EI   = 3'd5,
    EV_TRAP = 3'd6
  } evtId_e;

  // Where the saved return address comes from.
  typedef enum logic [1:0] {
    RET_CUR,
    RET_CUR4,
    RET_NEXT,
    RET_KEEP
  } retSel_e;

  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } pswBits_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    takeEvt;
    logic    doRte;
    logic    keepSm;
    retSel_e retSel;
    evtId_e  evtId;
  } ctlStrobe_t;

  // Highest priority first.
  localparam evtId_e PRIO_ORDER [NUM_EVT] = '{
    EV_RST, EV_AE, EV_RIE, EV_FPE, EV_TRAP, EV_SBI, EV_EI
  };

  function automatic retSel_e retRule(evtId_e id);
    case (id)
      EV_RIE, EV_AE:   return RET_CUR;
      EV_FPE, EV_TRAP: return RET_CUR4;
      EV_SBI, EV_EI:   return RET_NEXT;
      default:         return RET_KEEP;
    endcase
  endfunction

  function automatic logic smKept(evtId_e id);
    case (id)
      EV_RIE, EV_AE, EV_FPE, EV_TRAP: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction

  function automatic logic acceptOk(evtId_e id, logic exec, logic bnd,
                                    logic wb, logic ie);
    case (id)
      EV_RIE, EV_AE:   return exec;
      EV_FPE, EV_TRAP: return bnd;
      EV_RST:          return 1'b1;
      EV_SBI:          return bnd && wb;
      EV_EI:           return bnd && wb && ie;
      default:         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/excSeqCtrl.sv
module excSeqCtrl
  import excSeqPkg::*;
(
  input  logic [NUM_EVT-1:0] evtReq,
  input  logic               instExec,
  input  logic               instBoundary,
  input  logic               wordBoundary,
  input  logic               ieBit,
  input  logic               rteStrobe,
  output ctlStrobe_t         strb
);

  logic [NUM_EVT-1:0] eligible;
  logic               found;
  evtId_e             pick;

  // Each class gates its own request with its acceptance condition.
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_elig
    assign eligible[g] = evtReq[g] &&
      acceptOk(evtId_e'(g), instExec, instBoundary, wordBoundary, ieBit);
  end

  // Walk from lowest to highest priority so the highest one ends up in pick.
  always_comb begin
    found = 1'b0;
    pick  = EV_RIE;
    for (int k = NUM_EVT - 1; k >= 0; k--) begin
      if (eligible[PRIO_ORDER[k]]) begin
        found = 1'b1;
        pick  = PRIO_ORDER[k];
      end
    end
  end

  always_comb begin
    strb.takeEvt = found;
    strb.doRte   = rteStrobe && !found;
    strb.evtId   = pick;
    strb.retSel  = retRule(pick);
    strb.keepSm  = smKept(pick);
  end

endmodule

// File: rtl/excSeqDatapath.sv
module excSeqDatapath
  import excSeqPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_BASE   = 0,
  parameter int VEC_STRIDE = 16,
  parameter int INST_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [ADDR_W-1:0]  curPc,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic               pswWe,
  input  pswBits_t           pswWd,
  output pswBits_t           psw,
  output pswBits_t           bpsw,
  output logic [ADDR_W-1:0]  bpc,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcTarget,
  output logic [NUM_EVT-1:0] acceptVec
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [ADDR_W-1:0] vecAddr [NUM_EVT];
  logic [ADDR_W-1:0] retAddr;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_vec
    assign vecAddr[g] = ADDR_W'(VEC_BASE + g * VEC_STRIDE);
  end

  always_comb begin
    case (strb.retSel)
      RET_CUR:  retAddr = curPc;
      RET_CUR4: retAddr = curPc + STEP;
      RET_NEXT: retAddr = nextPc;
      default:  retAddr = bpc;
    endcase
  end

  // Status bits and their backups.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psw  <= '0;
      bpsw <= '0;
    end else if (strb.takeEvt) begin
      bpsw   <= psw;
      psw.sm <= strb.keepSm ? psw.sm : 1'b0;
      psw.ie <= 1'b0;
      psw.c  <= 1'b0;
    end else if (strb.doRte) begin
      psw <= bpsw;
    end else if (pswWe) begin
      psw <= pswWd;
    end
  end

  // Saved return address.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpc <= '0;
    end else if (strb.takeEvt && strb.retSel != RET_KEEP) begin
      bpc <= retAddr;
    end
  end

  // Program-counter load and accept report.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad    <= 1'b0;
      pcTarget  <= vecAddr[EV_RST];
      acceptVec <= '0;
    end else begin
      pcLoad <= strb.takeEvt || strb.doRte;
      if (strb.takeEvt) begin
        pcTarget  <= vecAddr[strb.evtId];
        acceptVec <= NUM_EVT'(1) << strb.evtId;
      end else begin
        acceptVec <= '0;
        if (strb.doRte) pcTarget <= bpc;
      end
    end
  end

endmodule

// File: rtl/excSequencer.sv
module excSequencer
  import excSeqPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_BASE   = 0,
  parameter int VEC_STRIDE = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtReq,
  input  logic [ADDR_W-1:0]  curPc,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic               instExec,
  input  logic               instBoundary,
  input  logic               wordBoundary,
  input  logic               rteStrobe,
  input  logic               pswWe,
  input  logic [2:0]         pswWd,
  output logic               pcLoad,
  output logic [ADDR_W-1:0]  pcTarget,
  output logic [NUM_EVT-1:0] acceptVec,
  output logic               smBit,
  output logic               ieBit,
  output logic               cBit,
  output logic               bsmBit,
  output logic               bieBit,
  output logic               bcBit,
  output logic [ADDR_W-1:0]  bpc
);

  ctlStrobe_t strb;
  pswBits_t   psw;
  pswBits_t   bpsw;
  pswBits_t   wrBits;

  assign wrBits = pswBits_t'(pswWd);

  excSeqCtrl ctrl_i (
    .evtReq      (evtReq),
    .instExec    (instExec),
    .instBoundary(instBoundary),
    .wordBoundary(wordBoundary),
    .ieBit       (psw.ie),
    .rteStrobe   (rteStrobe),
    .strb        (strb)
  );

  excSeqDatapath #(
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STRIDE(VEC_STRIDE)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .curPc    (curPc),
    .nextPc   (nextPc),
    .pswWe    (pswWe),
    .pswWd    (wrBits),
    .psw      (psw),
    .bpsw     (bpsw),
    .bpc      (bpc),
    .pcLoad   (pcLoad),
    .pcTarget (pcTarget),
    .acceptVec(acceptVec)
  );

  assign smBit  = psw.sm;
  assign ieBit  = psw.ie;
  assign cBit   = psw.c;
  assign bsmBit = bpsw.sm;
  assign bieBit = bpsw.ie;
  assign bcBit  = bpsw.c;

endmodule

// File: rtl/excSequencerChk.sv
module excSequencerChk
  import excSeqPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int VEC_BASE   = 0,
  parameter int VEC_STRIDE = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_EVT-1:0] evtReq,
  input logic [ADDR_W-1:0]  curPc,
  input logic               pcLoad,
  input logic [ADDR_W-1:0]  pcTarget,
  input logic [NUM_EVT-1:0] acceptVec,
  input logic               smBit,
  input logic               ieBit,
  input logic               cBit,
  input logic               bsmBit,
  input logic               bieBit,
  input logic               bcBit,
  input logic [ADDR_W-1:0]  bpc
);

  localparam logic [ADDR_W-1:0] RST_VEC =
    ADDR_W'(VEC_BASE + int'(EV_RST) * VEC_STRIDE);

  a_r10_onehot_accept: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(acceptVec));

  a_r10_accept_loads_pc: assert property (@(posedge clk) disable iff (!rstN)
    (|acceptVec) |-> pcLoad);

  a_r8_entry_clears: assert property (@(posedge clk) disable iff (!rstN)
    (|acceptVec) |-> (!ieBit && !cBit));

  a_r8_entry_backup: assert property (@(posedge clk) disable iff (!rstN)
    (|acceptVec) |-> (bsmBit == $past(smBit) && bieBit == $past(ieBit) &&
                      bcBit == $past(cBit)));

  a_r6_ei_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    acceptVec[EV_EI] |-> $past(ieBit));

  a_r5_mode_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (acceptVec[EV_SBI] || acceptVec[EV_EI] || acceptVec[EV_RST]) |-> !smBit);

  a_r2_fault_return_addr: assert property (@(posedge clk) disable iff (!rstN)
    acceptVec[EV_AE] |-> (bpc == $past(curPc) && smBit == $past(smBit)));

  a_r4_reset_event_any_cycle: assert property (@(posedge clk) disable iff (!rstN)
    evtReq[EV_RST] |=> (acceptVec[EV_RST] && pcTarget == RST_VEC));

  a_r9_reset_over_fault: assert property (@(posedge clk) disable iff (!rstN)
    (evtReq[EV_RST] && evtReq[EV_AE]) |=> !acceptVec[EV_AE]);

  a_r11_return_restores: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !(|acceptVec)) |->
      (pcTarget == $past(bpc) && smBit == $past(bsmBit) &&
       ieBit == $past(bieBit) && cBit == $past(bcBit)));

endmodule

bind excSequencer excSequencerChk #(
  .ADDR_W    (ADDR_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .evtReq   (evtReq),
  .curPc    (curPc),
  .pcLoad   (pcLoad),
  .pcTarget (pcTarget),
  .acceptVec(acceptVec),
  .smBit    (smBit),
  .ieBit    (ieBit),
  .cBit     (cBit),
  .bsmBit   (bsmBit),
  .bieBit   (bieBit),
  .bcBit    (bcBit),
  .bpc      (bpc)
);

// File: tb/excSequencer_tb_top.sv
module excSequencer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  evtReq = '0;
  logic [31:0] curPc = '0;
  logic [31:0] nextPc = '0;
  logic        instExec = 1'b0;
  logic        instBoundary = 1'b0;
  logic        wordBoundary = 1'b0;
  logic        rteStrobe = 1'b0;
  logic        pswWe = 1'b0;
  logic [2:0]  pswWd = '0;
  logic        pcLoad;
  logic [31:0] pcTarget;
  logic [6:0]  acceptVec;
  logic        smBit, ieBit, cBit, bsmBit, bieBit, bcBit;
  logic [31:0] bpc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  excSequencer dut_i (
    .clk(clk), .rstN(rstN), .evtReq(evtReq), .curPc(curPc), .nextPc(nextPc),
    .instExec(instExec), .instBoundary(instBoundary),
    .wordBoundary(wordBoundary), .rteStrobe(rteStrobe), .pswWe(pswWe),
    .pswWd(pswWd), .pcLoad(pcLoad), .pcTarget(pcTarget),
    .acceptVec(acceptVec), .smBit(smBit), .ieBit(ieBit), .cBit(cBit),
    .bsmBit(bsmBit), .bieBit(bieBit), .bcBit(bcBit), .bpc(bpc)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic [6:0]  req;
    logic [31:0] cur;
    logic [31:0] nxt;
    logic        ex, bnd, wb, rte, we;
    logic [2:0]  wd;
    logic        eLoad;
    logic [31:0] eTgt;
    logic [6:0]  eAcc;
    logic [2:0]  ePsw;
    logic [2:0]  eBpsw;
    logic [31:0] eBpc;
  } row_t;

  localparam int NROWS = 37;
  // Fields: tag req cur nxt ex bnd wb rte we wd | load tgt acc psw bpsw bpc
  localparam row_t TBL [NROWS] = '{
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b111, 0, 32'h00, 7'h00, 3'b111, 3'b000, 32'h000}, // R12
    '{ 2, 7'h01, 32'h100, 32'h104, 0,0,0,0,0, 3'b000, 0, 32'h00, 7'h00, 3'b111, 3'b000, 32'h000}, // R2 ignored
    '{ 2, 7'h01, 32'h100, 32'h104, 1,0,0,0,0, 3'b000, 1, 32'h00, 7'h01, 3'b100, 3'b111, 32'h100}, // R2 R8
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b011, 0, 32'h00, 7'h00, 3'b011, 3'b111, 32'h100}, // R12
    '{11, 7'h00, 32'h000, 32'h000, 0,0,0,1,0, 3'b000, 1, 32'h100,7'h00, 3'b111, 3'b111, 32'h100}, // R11
    '{ 2, 7'h02, 32'h204, 32'h208, 1,0,0,0,0, 3'b000, 1, 32'h10, 7'h02, 3'b100, 3'b111, 32'h204}, // R2
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b010, 0, 32'h00, 7'h00, 3'b010, 3'b111, 32'h204}, // R12
    '{ 3, 7'h04, 32'h300, 32'h304, 1,0,0,0,0, 3'b000, 0, 32'h00, 7'h00, 3'b010, 3'b111, 32'h204}, // R3 ignored
    '{ 3, 7'h04, 32'h300, 32'h304, 0,1,0,0,0, 3'b000, 1, 32'h20, 7'h04, 3'b000, 3'b010, 32'h304}, // R3
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b111, 0, 32'h00, 7'h00, 3'b111, 3'b010, 32'h304}, // R12
    '{ 5, 7'h20, 32'h400, 32'h408, 0,1,0,0,0, 3'b000, 0, 32'h00, 7'h00, 3'b111, 3'b010, 32'h304}, // R5 not word
    '{ 5, 7'h20, 32'h400, 32'h408, 0,1,1,0,0, 3'b000, 1, 32'h50, 7'h20, 3'b000, 3'b111, 32'h408}, // R5
    '{ 6, 7'h20, 32'h400, 32'h40C, 0,1,1,0,0, 3'b000, 0, 32'h00, 7'h00, 3'b000, 3'b111, 32'h408}, // R6 masked
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b101, 0, 32'h00, 7'h00, 3'b101, 3'b111, 32'h408}, // R12
    '{ 5, 7'h10, 32'h4F0, 32'h500, 0,1,1,0,0, 3'b000, 1, 32'h40, 7'h10, 3'b000, 3'b101, 32'h500}, // R5
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b100, 0, 32'h00, 7'h00, 3'b100, 3'b101, 32'h500}, // R12
    '{ 7, 7'h40, 32'h600, 32'h608, 0,1,0,0,0, 3'b000, 1, 32'h60, 7'h40, 3'b100, 3'b100, 32'h604}, // R7
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b111, 0, 32'h00, 7'h00, 3'b111, 3'b100, 32'h604}, // R12
    '{ 4, 7'h08, 32'h650, 32'h654, 0,0,0,0,0, 3'b000, 1, 32'h30, 7'h08, 3'b000, 3'b111, 32'h604}, // R4
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b110, 0, 32'h00, 7'h00, 3'b110, 3'b111, 32'h604}, // R12
    '{ 9, 7'h7F, 32'h700, 32'h710, 1,1,1,0,0, 3'b000, 1, 32'h30, 7'h08, 3'b000, 3'b110, 32'h604}, // R9 reset first
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b111, 0, 32'h00, 7'h00, 3'b111, 3'b110, 32'h604}, // R12
    '{ 9, 7'h77, 32'h700, 32'h710, 1,1,1,0,0, 3'b000, 1, 32'h10, 7'h02, 3'b100, 3'b111, 32'h700}, // R9 fault
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b011, 0, 32'h00, 7'h00, 3'b011, 3'b111, 32'h700}, // R12
    '{ 9, 7'h75, 32'h800, 32'h810, 1,1,1,0,0, 3'b000, 1, 32'h00, 7'h01, 3'b000, 3'b011, 32'h800}, // R9 reserved
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b011, 0, 32'h00, 7'h00, 3'b011, 3'b011, 32'h800}, // R12
    '{ 9, 7'h74, 32'h900, 32'h910, 0,1,1,0,0, 3'b000, 1, 32'h20, 7'h04, 3'b000, 3'b011, 32'h904}, // R9 fp
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b011, 0, 32'h00, 7'h00, 3'b011, 3'b011, 32'h904}, // R12
    '{ 9, 7'h70, 32'hA00, 32'hA10, 0,1,1,0,0, 3'b000, 1, 32'h60, 7'h40, 3'b000, 3'b011, 32'hA04}, // R9 trap
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b011, 0, 32'h00, 7'h00, 3'b011, 3'b011, 32'hA04}, // R12
    '{ 9, 7'h30, 32'hB00, 32'hB10, 0,1,1,0,0, 3'b000, 1, 32'h40, 7'h10, 3'b000, 3'b011, 32'hB10}, // R9 sbi
    '{ 9, 7'h42, 32'hC00, 32'hC10, 0,1,0,0,0, 3'b000, 1, 32'h60, 7'h40, 3'b000, 3'b000, 32'hC04}, // R9 ineligible skip
    '{12, 7'h00, 32'h000, 32'h000, 0,0,0,0,1, 3'b111, 0, 32'h00, 7'h00, 3'b111, 3'b000, 32'hC04}, // R12
    '{11, 7'h40, 32'hD00, 32'hD10, 0,1,0,1,0, 3'b000, 1, 32'h60, 7'h40, 3'b100, 3'b111, 32'hD04}, // R11 event wins
    '{11, 7'h00, 32'h000, 32'h000, 0,0,0,1,0, 3'b000, 1, 32'hD04,7'h00, 3'b111, 3'b111, 32'hD04}, // R11
    '{12, 7'h40, 32'hE00, 32'hE10, 0,1,0,0,1, 3'b000, 1, 32'h60, 7'h40, 3'b100, 3'b111, 32'hE04}, // R12 event over write
    '{10, 7'h00, 32'h000, 32'h000, 0,0,0,0,0, 3'b000, 0, 32'h00, 7'h00, 3'b100, 3'b111, 32'hE04}  // R10 pulse ends
  };

  task automatic chk(string what, int tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkReset();
    // R1 reset state
    chk("r1 pcLoad", 1, 32'(pcLoad), 0);
    chk("r1 acceptVec", 1, 32'(acceptVec), 0);
    chk("r1 pcTarget", 1, pcTarget, 32'h30);
    chk("r1 psw", 1, 32'({smBit, ieBit, cBit}), 0);
    chk("r1 bpsw", 1, 32'({bsmBit, bieBit, bcBit}), 0);
    chk("r1 bpc", 1, bpc, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 checkReset();
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      evtReq = TBL[i].req; curPc = TBL[i].cur; nextPc = TBL[i].nxt;
      instExec = TBL[i].ex; instBoundary = TBL[i].bnd;
      wordBoundary = TBL[i].wb; rteStrobe = TBL[i].rte;
      pswWe = TBL[i].we; pswWd = TBL[i].wd;
      @(posedge clk);
      #1;
      chk($sformatf("row %0d pcLoad", i), int'(TBL[i].tag), 32'(pcLoad), 32'(TBL[i].eLoad));
      chk($sformatf("row %0d acceptVec", i), int'(TBL[i].tag), 32'(acceptVec), 32'(TBL[i].eAcc));
      chk($sformatf("row %0d psw", i), int'(TBL[i].tag), 32'({smBit, ieBit, cBit}), 32'(TBL[i].ePsw));
      chk($sformatf("row %0d bpsw", i), int'(TBL[i].tag), 32'({bsmBit, bieBit, bcBit}), 32'(TBL[i].eBpsw));
      chk($sformatf("row %0d bpc", i), int'(TBL[i].tag), bpc, TBL[i].eBpc);
      if (TBL[i].eLoad)
        chk($sformatf("row %0d pcTarget", i), int'(TBL[i].tag), pcTarget, TBL[i].eTgt);
    end

    // R4: reset event taken while an instruction is mid-execution, no boundary
    @(negedge clk);
    evtReq = 7'h08; instExec = 1'b1; instBoundary = 1'b0; wordBoundary = 1'b0;
    rteStrobe = 1'b0; pswWe = 1'b0;
    @(posedge clk); #1;
    chk("r4 mid-exec accept", 4, 32'(acceptVec), 32'h08);
    chk("r4 mid-exec target", 4, pcTarget, 32'h30);
    @(negedge clk);
    evtReq = '0; instExec = 1'b0;
    @(posedge clk); #1;
    chk("r10 pulse one cycle", 10, 32'(pcLoad), 0);

    // R1: asynchronous reset in the middle of operation
    @(negedge clk);
    pswWe = 1'b1; pswWd = 3'b111;
    @(posedge clk); #1;
    chk("r12 write before reset", 12, 32'({smBit, ieBit, cBit}), 32'h7);
    @(negedge clk);
    pswWe = 1'b0;
    #2 rstN = 1'b0;
    #1 checkReset();
    @(negedge clk) rstN = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule